// File: doc/BRIEF.md
# Composite-Field AES Forward S-Box

This block performs the forward byte substitution of the AES cipher without a 256-entry lookup table. The incoming byte is moved by a linear change of basis into a tower field, built as degree-two extensions over GF(2^4). In that field the multiplicative inverse needs only nibble-wide multipliers, one squarer, a multiply by a fixed constant and a 4-bit inverter. The inverse is moved back to the standard byte basis, and the affine step then produces the substituted byte.

A build parameter selects one of two variants. The combinational variant has no registers on the data path, so the result follows the input in the same cycle. The pipelined variant splits the path into three stages of similar depth and accepts a new byte on every clock. A valid flag travels with each byte so that the output flag stays aligned with the output data. An encryption round engine would typically instantiate one or more of these blocks and choose the variant to suit its clock target.

Top module: `aes_cf_sbox`

## Requirements
- R1: For every input byte 0x00 to 0xFF the output equals the AES forward S-box value, for example 0x01 gives 0x7C and 0x53 gives 0xED.
- R2: With PIPELINED=1, a byte sampled with in_valid high at a rising edge appears on out_byte with out_valid high exactly three rising edges later. A cycle with in_valid low gives out_valid low three edges later.
- R3: With PIPELINED=0, out_byte and out_valid are combinational functions of in_byte and in_valid. They take their new values in the same cycle, before the next rising edge.
- R4: With PIPELINED=1, a new byte is accepted on every cycle. Back-to-back streams and streams with idle gaps both leave the block in their original order, with none lost or duplicated.
- R5: rst is synchronous and active high. After any rising edge with rst high, out_valid is low. Bytes that were in flight when reset was applied never appear with out_valid high.
- R6: The zero byte, which has no multiplicative inverse, is treated as having inverse 0x00, so its output is 0x63.
- R7: The affine step sets output bit i to the XOR of inverse bits i, (i+4) mod 8, (i+5) mod 8, (i+6) mod 8 and (i+7) mod 8, together with bit i of 0x63. Bit 0 is the least significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipeline registers |
| rst | input | 1 | Synchronous reset, active high; clears the valid flags |
| in_valid | input | 1 | Marks in_byte as carrying a byte to substitute |
| in_byte | input | 8 | Byte to be substituted |
| out_valid | output | 1 | Marks out_byte as carrying a result |
| out_byte | output | 8 | Substituted byte |

## Verification
The bench builds two instances side by side on the same stimulus: one with PIPELINED=1 and one with PIPELINED=0. The byte is eight bits wide, so every possible input is applied to both instances. This is done first as one unbroken stream and again as a permuted stream with idle gaps. Each result is compared with a table computed from GF(2^8) arithmetic in the standard basis, which tests the isomorphism and every tower-field subunit on all their operands. The pipelined instance also has its valid flag checked on every cycle, and it is reset while holding live bytes to show that none of them later appear.

// File: rtl/aes_cf_pkg.sv
package aes_cf_pkg;

  localparam int BYTE_W      = 8;
  localparam int NIB_W       = 4;
  localparam int PIPE_STAGES = 3;
  localparam int MAP_W       = BYTE_W * BYTE_W;

  // x^2 + x + LAMBDA is irreducible over GF(2^4) with x^4 + x + 1
  localparam logic [NIB_W-1:0]  LAMBDA   = 4'hC;
  localparam logic [BYTE_W-1:0] AFF_C    = 8'h63;
  localparam logic [BYTE_W:0]   AES_POLY = 9'h11B;

  // GF(2^4) product, reduction polynomial x^4 + x + 1
  function automatic logic [NIB_W-1:0] nib_mul(input logic [NIB_W-1:0] a,
                                               input logic [NIB_W-1:0] b);
    logic [2*NIB_W-2:0] t;
    t = '0;
    for (int i = 0; i < NIB_W; i++)
      if (b[i]) t = t ^ ({{(NIB_W-1){1'b0}}, a} << i);
    return {t[3] ^ t[6], t[2] ^ t[5] ^ t[6], t[1] ^ t[4] ^ t[5], t[0] ^ t[4]};
  endfunction

  // Tower-field product; element = {hi, lo} meaning hi*x + lo, x^2 = x + LAMBDA
  function automatic logic [BYTE_W-1:0] cf_mul(input logic [BYTE_W-1:0] p,
                                               input logic [BYTE_W-1:0] q);
    logic [NIB_W-1:0] hh, hl, lh, ll;
    hh = nib_mul(p[7:4], q[7:4]);
    hl = nib_mul(p[7:4], q[3:0]);
    lh = nib_mul(p[3:0], q[7:4]);
    ll = nib_mul(p[3:0], q[3:0]);
    return {hh ^ hl ^ lh, nib_mul(hh, LAMBDA) ^ ll};
  endfunction

  // Tower-field element that is a root of the AES field polynomial
  function automatic logic [BYTE_W-1:0] cf_root();
    logic [BYTE_W-1:0] cand, pw, acc;
    for (int k = 2; k < 256; k++) begin
      cand = BYTE_W'(k);
      pw   = 8'h01;
      acc  = '0;
      for (int e = 0; e <= BYTE_W; e++) begin
        if (AES_POLY[e]) acc = acc ^ pw;
        pw = cf_mul(pw, cand);
      end
      if (acc == '0) return cand;
    end
    return '0;
  endfunction

  // Column i of the forward map is the image of standard basis bit i (root^i)
  function automatic logic [MAP_W-1:0] fwd_cols(input logic [BYTE_W-1:0] root);
    logic [MAP_W-1:0]  cols;
    logic [BYTE_W-1:0] pw;
    pw = 8'h01;
    for (int i = 0; i < BYTE_W; i++) begin
      cols[BYTE_W*i +: BYTE_W] = pw;
      pw = cf_mul(pw, root);
    end
    return cols;
  endfunction

  // Inverse of a GF(2) matrix given by columns, Gauss-Jordan elimination
  function automatic logic [MAP_W-1:0] inv_cols(input logic [MAP_W-1:0] cols);
    logic [BYTE_W-1:0][BYTE_W-1:0] a, m;
    logic [BYTE_W-1:0]             tmp;
    logic [MAP_W-1:0]              res;
    for (int r = 0; r < BYTE_W; r++) begin
      for (int i = 0; i < BYTE_W; i++) a[r][i] = cols[BYTE_W*i + r];
      m[r] = BYTE_W'(1) << r;
    end
    for (int c = 0; c < BYTE_W; c++) begin
      for (int r = c; r < BYTE_W; r++)
        if (a[r][c] && !a[c][c]) begin
          tmp = a[r]; a[r] = a[c]; a[c] = tmp;
          tmp = m[r]; m[r] = m[c]; m[c] = tmp;
        end
      for (int r = 0; r < BYTE_W; r++)
        if (r != c && a[r][c]) begin
          a[r] = a[r] ^ a[c];
          m[r] = m[r] ^ m[c];
        end
    end
    for (int r = 0; r < BYTE_W; r++)
      for (int i = 0; i < BYTE_W; i++) res[BYTE_W*i + r] = m[r][i];
    return res;
  endfunction

  localparam logic [BYTE_W-1:0] CF_ROOT        = cf_root();
  localparam logic [MAP_W-1:0]  DELTA_COLS     = fwd_cols(CF_ROOT);
  localparam logic [MAP_W-1:0]  DELTA_INV_COLS = inv_cols(DELTA_COLS);

endpackage

// File: rtl/gf4_mul.sv
module gf4_mul
  import aes_cf_pkg::*;
(
  input  logic [NIB_W-1:0] a,
  input  logic [NIB_W-1:0] b,
  output logic [NIB_W-1:0] p
);
  localparam int PW = 2*NIB_W - 1;

  logic [PW-1:0] pp [NIB_W];
  logic [PW-1:0] t;

  genvar i;
  generate
    for (i = 0; i < NIB_W; i++) begin : g_pp
      assign pp[i] = b[i] ? ({{(NIB_W-1){1'b0}}, a} << i) : '0;
    end
  endgenerate

  always_comb begin
    t = '0;
    for (int k = 0; k < NIB_W; k++) t = t ^ pp[k];
  end

  // fold x^4 = x + 1, x^5 = x^2 + x, x^6 = x^3 + x^2
  assign p = {t[3] ^ t[6], t[2] ^ t[5] ^ t[6], t[1] ^ t[4] ^ t[5], t[0] ^ t[4]};
endmodule

// File: rtl/gf4_sq.sv
module gf4_sq
  import aes_cf_pkg::*;
(
  input  logic [NIB_W-1:0] a,
  output logic [NIB_W-1:0] s
);
  // squaring is linear: a0 + a1 x^2 + a2 (x + 1) + a3 (x^3 + x^2)
  assign s = {a[3], a[1] ^ a[3], a[2], a[0] ^ a[2]};
endmodule

// File: rtl/gf4_inv.sv
module gf4_inv
  import aes_cf_pkg::*;
(
  input  logic [NIB_W-1:0] a,
  output logic [NIB_W-1:0] y
);
  // y = a^14 (zero maps to zero)
  logic [NIB_W-1:0] a2, a4, a8, a6;

  gf4_sq  u_sq1 (.a(a),  .s(a2));
  gf4_sq  u_sq2 (.a(a2), .s(a4));
  gf4_sq  u_sq3 (.a(a4), .s(a8));
  gf4_mul u_m6  (.a(a2), .b(a4), .p(a6));
  gf4_mul u_m14 (.a(a6), .b(a8), .p(y));
endmodule

// File: rtl/gf8_lin_map.sv
module gf8_lin_map
  import aes_cf_pkg::*;
#(
  parameter logic [MAP_W-1:0] COLS = DELTA_COLS
)(
  input  logic [BYTE_W-1:0] v_in,
  output logic [BYTE_W-1:0] v_out
);
  logic [BYTE_W-1:0] term [BYTE_W];

  genvar i;
  generate
    for (i = 0; i < BYTE_W; i++) begin : g_term
      assign term[i] = v_in[i] ? COLS[BYTE_W*i +: BYTE_W] : '0;
    end
  endgenerate

  always_comb begin
    v_out = '0;
    for (int k = 0; k < BYTE_W; k++) v_out = v_out ^ term[k];
  end
endmodule

// File: rtl/sbox_affine.sv
module sbox_affine
  import aes_cf_pkg::*;
(
  input  logic [BYTE_W-1:0] x,
  output logic [BYTE_W-1:0] y
);
  genvar i;
  generate
    for (i = 0; i < BYTE_W; i++) begin : g_bit
      assign y[i] = x[i] ^ x[(i+4)%BYTE_W] ^ x[(i+5)%BYTE_W]
                  ^ x[(i+6)%BYTE_W] ^ x[(i+7)%BYTE_W] ^ AFF_C[i];
    end
  endgenerate
endmodule

// File: rtl/aes_cf_sbox.sv
module aes_cf_sbox
  import aes_cf_pkg::*;
#(
  parameter bit PIPELINED = 1'b1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte
);

  // ---------------- stage A: basis change and norm ----------------
  logic [BYTE_W-1:0] a_cf;
  logic [NIB_W-1:0]  a_hi, a_lo, a_sum, a_sq, a_sql, a_cross, a_det;

  gf8_lin_map #(.COLS(DELTA_COLS)) u_fwd (.v_in(in_byte), .v_out(a_cf));

  assign a_hi  = a_cf[BYTE_W-1:NIB_W];
  assign a_lo  = a_cf[NIB_W-1:0];
  assign a_sum = a_hi ^ a_lo;

  gf4_sq  u_sq   (.a(a_hi),  .s(a_sq));
  gf4_mul u_lam  (.a(a_sq),  .b(LAMBDA), .p(a_sql));
  gf4_mul u_crs  (.a(a_lo),  .b(a_sum),  .p(a_cross));

  assign a_det = a_sql ^ a_cross;

  // stage A -> B
  logic             s1_v;
  logic [NIB_W-1:0] s1_hi, s1_sum, s1_det;

  // ---------------- stage B: norm inversion ----------------
  logic [NIB_W-1:0] b_dinv;

  gf4_inv u_inv (.a(s1_det), .y(b_dinv));

  // stage B -> C
  logic             s2_v;
  logic [NIB_W-1:0] s2_hi, s2_sum, s2_dinv;

  // ---------------- stage C: scale, map back, affine ----------------
  logic [NIB_W-1:0]  c_hi, c_lo;
  logic [BYTE_W-1:0] c_inv, c_byte;

  gf4_mul u_mhi (.a(s2_hi),  .b(s2_dinv), .p(c_hi));
  gf4_mul u_mlo (.a(s2_sum), .b(s2_dinv), .p(c_lo));

  gf8_lin_map #(.COLS(DELTA_INV_COLS)) u_bwd (.v_in({c_hi, c_lo}), .v_out(c_inv));

  sbox_affine u_aff (.x(c_inv), .y(c_byte));

  generate
    if (PIPELINED) begin : g_pipe
      logic              s3_v;
      logic [BYTE_W-1:0] s3_byte;

      always_ff @(posedge clk) begin
        if (rst) begin
          s1_v <= 1'b0;
          s2_v <= 1'b0;
          s3_v <= 1'b0;
        end else begin
          s1_v <= in_valid;
          s2_v <= s1_v;
          s3_v <= s2_v;
        end
      end

      always_ff @(posedge clk) begin
        s1_hi   <= a_hi;
        s1_sum  <= a_sum;
        s1_det  <= a_det;
        s2_hi   <= s1_hi;
        s2_sum  <= s1_sum;
        s2_dinv <= b_dinv;
        s3_byte <= c_byte;
      end

      assign out_valid = s3_v;
      assign out_byte  = s3_byte;

      // R2: valid flag emerges exactly three edges later
      a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##PIPE_STAGES out_valid);
      a_r2_idle_latency: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##PIPE_STAGES !out_valid);
      // R5: any reset edge leaves the output invalid
      a_r5_reset_flush: assert property (@(posedge clk)
        rst |=> !out_valid);
      // R6: zero input lands as 0x63 after the pipeline
      a_r6_zero_piped: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_byte == '0) |-> ##PIPE_STAGES (out_byte == AFF_C));
    end else begin : g_comb
      assign s1_v      = in_valid;
      assign s1_hi     = a_hi;
      assign s1_sum    = a_sum;
      assign s1_det    = a_det;
      assign s2_v      = s1_v;
      assign s2_hi     = s1_hi;
      assign s2_sum    = s1_sum;
      assign s2_dinv   = b_dinv;
      assign out_valid = s2_v;
      assign out_byte  = c_byte;

      // R3: no state on the data path
      a_r3_no_state: assert property (@(posedge clk) disable iff (rst)
        $stable(in_byte) |-> $stable(out_byte));
      // R6: zero input gives 0x63 in the same cycle
      a_r6_zero_comb: assert property (@(posedge clk) disable iff (rst)
        (in_byte == '0) |-> (out_byte == AFF_C));
    end
  endgenerate

  // R1: the norm vanishes only for the zero element
  a_r1_det_zero_iff_zero: assert property (@(posedge clk) disable iff (rst)
    (a_det == '0) == (a_cf == '0));
  // R1: stage B inverter output is the true inverse of its operand
  a_r1_norm_inverse: assert property (@(posedge clk) disable iff (rst)
    (s1_det != '0) |-> (nib_mul(s1_det, b_dinv) == 4'h1));

endmodule

// File: tb/aes_cf_sbox_bench.sv
module aes_cf_sbox_bench;

  localparam int CLK_P    = 10;
  localparam int WATCHDOG = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte  = 8'h00;

  logic       p_valid, c_valid;
  logic [7:0] p_byte,  c_byte;

  int n_chk = 0;
  int n_bad = 0;

  logic       h_v [3];
  logic [7:0] h_d [3];

  always #(CLK_P/2) clk = ~clk;

  aes_cf_sbox #(.PIPELINED(1'b1)) u_aes_cf_sbox (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(p_valid), .out_byte(p_byte));

  aes_cf_sbox #(.PIPELINED(1'b0)) u_aes_cf_sbox_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(c_valid), .out_byte(c_byte));

  // reference arithmetic in the standard basis, polynomial 0x11B
  function automatic logic [7:0] gf8_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, x;
    r = '0; x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] gf8_inv(input logic [7:0] a);
    logic [7:0] r, s, e;
    r = 8'h01; s = a; e = 8'd254;
    for (int k = 0; k < 8; k++) begin
      if (e[k]) r = gf8_mul(r, s);
      s = gf8_mul(s, s);
    end
    return r;
  endfunction

  // R7: affine bit i = x[i]^x[i+4]^x[i+5]^x[i+6]^x[i+7]^0x63[i]
  function automatic logic [7:0] ref_sbox(input logic [7:0] v);
    logic [7:0] x, y, c;
    x = gf8_inv(v); c = 8'h63;
    for (int i = 0; i < 8; i++)
      y[i] = x[i] ^ x[(i+4)%8] ^ x[(i+5)%8] ^ x[(i+6)%8] ^ x[(i+7)%8] ^ c[i];
    return y;
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int k = 0; k < 3; k++) begin h_v[k] = 1'b0; h_d[k] = 8'h00; end
  endtask

  // one cycle: check pipelined output for the byte driven three cycles ago,
  // drive the new byte, then check the combinational instance before the edge
  task automatic tick(input logic v, input logic [7:0] d);
    @(negedge clk);
    check1("R2 pipelined valid", p_valid, h_v[2]);
    if (h_v[2]) check8("R1/R4 pipelined data", p_byte, ref_sbox(h_d[2]));
    h_v[2] = h_v[1]; h_d[2] = h_d[1];
    h_v[1] = h_v[0]; h_d[1] = h_d[0];
    h_v[0] = v;      h_d[0] = d;
    in_valid = v;
    in_byte  = d;
    #1;
    check1("R3 combinational valid", c_valid, v);
    check8("R1/R3 combinational data", c_byte, ref_sbox(d));
  endtask

  task automatic hold_reset(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      check1("R5 valid under reset", p_valid, 1'b0);
    end
    rst = 1'b0;
    clear_hist();
  endtask

  initial begin : watchdog
    #(CLK_P * WATCHDOG);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog: got run still active expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    clear_hist();
    hold_reset(3);

    // R6 / R1 known points
    tick(1'b1, 8'h00);
    check8("R6 zero byte", c_byte, 8'h63);
    tick(1'b1, 8'h01);
    check8("R1 byte 01", c_byte, 8'h7C);
    tick(1'b1, 8'h53);
    check8("R1 byte 53", c_byte, 8'hED);
    check8("R7 reference affine", ref_sbox(8'h53), 8'hED);

    // R4: every byte back to back
    for (int i = 0; i < 256; i++) tick(1'b1, 8'(i));

    // R4: permuted order with idle gaps
    for (int i = 0; i < 256; i++) tick((i % 3) != 0, 8'((i * 167 + 29) & 255));
    for (int i = 0; i < 256; i += 3) tick(1'b1, 8'((i * 167 + 29) & 255));

    // R5: reset with bytes in flight; none may emerge afterwards
    tick(1'b1, 8'hA5);
    tick(1'b1, 8'h3C);
    hold_reset(1);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check1("R5 no stale valid", p_valid, 1'b0);
    end

    // R2: pipeline recovers after reset
    tick(1'b1, 8'hFF);
    for (int c = 0; c < 4; c++) tick(1'b0, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule